// File: doc/BRIEF.md
# Lockable Non-Maskable Interrupt Edge Detector

This block turns transitions on an external interrupt pin into a request that goes straight to the processor core. No interrupt controller sits in the path, and the request has no mask. The pin is asynchronous, so it passes through a two-stage synchroniser before the block compares its current and previous sampled levels.

Software picks the active edge: rising, falling or both. It then sets an enable bit through a small write/read configuration port. Setting the enable bit freezes the configuration: the block ignores every later write, and only reset returns it to the unprogrammed state. A detected edge sets a pending flag, which drives the request output. The flag stays set until the core pulses the acknowledge input.

Top module: `nmi_edge_lock`

## Requirements
- R1: After reset the request output is 0 and the configuration readback is 3'b000.
- R2: While the enable bit (bit 2) reads 0, a write stores all three bits, and the readback shows the written value on the following cycle.
- R3: A write with bit 2 set locks the configuration. Later writes of any value leave the readback unchanged until reset.
- R4: Edge select (bits 1:0) value 2'b01 means rising edges only. With that setting and enabled, a low-to-high pin transition raises the request and a high-to-low transition does not.
- R5: Edge select 2'b10 means falling edges only. With that setting and enabled, a high-to-low pin transition raises the request and a low-to-high transition does not.
- R6: Edge select 2'b11 means both edges. With that setting and enabled, transitions in either direction raise the request.
- R7: With the enable bit clear, or with edge select 2'b00, no pin transition raises the request.
- R8: The request goes high on the third rising clock edge after the pin changes ahead of a clock edge. It is still low after the second.
- R9: Once raised, the request stays high with no acknowledge. An acknowledge with no new edge clears it on the next clock.
- R10: An edge detected in the same cycle as an acknowledge leaves the request high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Write data: bit 2 enable/lock, bits 1:0 edge select |
| cfg_rdata | output | 3 | Current configuration |
| ack_i | input | 1 | Acknowledge pulse from the core |
| nmi_req_o | output | 1 | Non-maskable request to the core |

## Verification
The bench sends both edge directions through every select value. A decoder with a swapped select encoding would fire on the wrong direction or stay silent. The bench writes after locking: a block that still accepted writes would show a changed readback. It lines up an edge with an acknowledge: a design where clear beats set would drop the request. Exact-cycle sampling catches a synchroniser that is one stage too short or too long.

// File: rtl/nmi_edge_lock.sv
module nmi_edge_lock #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  output logic [2:0] cfg_rdata,
  input  logic       ack_i,
  output logic       nmi_req_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [1:0]             sel_q;
  logic                   en_q;
  logic                   pend_q;

  wire pin_s = sync_q[SYNC_STAGES-1];
  wire rise  = pin_s & ~prev_q;
  wire fall  = ~pin_s & prev_q;
  wire det   = en_q & ((sel_q[0] & rise) | (sel_q[1] & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
      en_q  <= 1'b0;
    end else if (cfg_we && !en_q) begin
      sel_q <= cfg_wdata[1:0];
      en_q  <= cfg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (det)   pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign cfg_rdata = {en_q, sel_q};
  assign nmi_req_o = pend_q;

  // R3: a locked configuration never changes
  a_r3_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(cfg_rdata));

  // R7: without enable no request can appear
  a_r7_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !nmi_req_o) |=> !nmi_req_o);

  // R9: request holds without acknowledge
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req_o && !ack_i) |=> nmi_req_o);

  // R9: acknowledge without edge clears
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !det) |=> !nmi_req_o);

  // R10: edge wins over acknowledge
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (det && ack_i) |=> nmi_req_o);

endmodule

// File: tb/nmi_edge_lock_tb_top.sv
module nmi_edge_lock_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, pin_i = 1'b0, cfg_we = 1'b0, ack_i = 1'b0;
  logic [2:0] cfg_wdata = 3'b000;
  logic [2:0] cfg_rdata;
  logic nmi_req_o;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_edge_lock dut_i (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ack_i(ack_i), .nmi_req_o(nmi_req_o));

  // {lock, sel[1:0], rising, expect}
  localparam logic [4:0] VEC [8] = '{
    5'b1_01_1_1, 5'b1_01_0_0, 5'b1_10_1_0, 5'b1_10_0_1,
    5'b1_11_1_1, 5'b1_11_0_1, 5'b1_00_1_0, 5'b0_01_1_0 };
  localparam string VREQ [8] = '{"R4","R4","R5","R5","R6","R6","R7","R7"};

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; ack_i = 1'b0;
    step(2); rst_n = 1'b1; step(1);
  endtask

  task automatic wr(logic [2:0] d);
    cfg_we = 1'b1; cfg_wdata = d; step(1); cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1", {2'b00, nmi_req_o}, 3'b000);
    chk("R1", cfg_rdata, 3'b000);

    for (int v = 0; v < 8; v++) begin
      pin_i = ~VEC[v][1];
      do_reset(); step(4);
      wr({VEC[v][4], VEC[v][3:2]});
      pin_i = VEC[v][1];
      step(5);
      chk(VREQ[v], {2'b00, nmi_req_o}, {2'b00, VEC[v][0]});
    end

    // R2 and R3: writes before and after lock
    pin_i = 1'b0; do_reset();
    wr(3'b010); chk("R2", cfg_rdata, 3'b010);
    wr(3'b001); chk("R2", cfg_rdata, 3'b001);
    wr(3'b111); chk("R3", cfg_rdata, 3'b111);
    wr(3'b000); chk("R3", cfg_rdata, 3'b111);
    wr(3'b101); chk("R3", cfg_rdata, 3'b111);

    // R8 latency, R9 hold and clear, R10 edge with ack
    step(3);
    pin_i = 1'b1; step(2);
    chk("R8", {2'b00, nmi_req_o}, 3'b000);
    step(1);
    chk("R8", {2'b00, nmi_req_o}, 3'b001);
    step(6);
    chk("R9", {2'b00, nmi_req_o}, 3'b001);
    pin_i = 1'b0; step(2);
    ack_i = 1'b1; step(1); ack_i = 1'b0;
    chk("R10", {2'b00, nmi_req_o}, 3'b001);
    ack_i = 1'b1; step(1); ack_i = 1'b0;
    chk("R9", {2'b00, nmi_req_o}, 3'b000);
    step(3);
    chk("R9", {2'b00, nmi_req_o}, 3'b000);

    // R7: edges after reset with nothing enabled
    do_reset(); pin_i = 1'b1; step(5); pin_i = 1'b0; step(5);
    chk("R7", {2'b00, nmi_req_o}, 3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule